// File: doc/BRIEF.md
# Cyclic-Slot Ingress Admission Control

This block decides, one descriptor per clock, whether a packet may enter a single shared transmit FIFO that is run as a cyclic slot scheduler. Time, taken from a synchronized time input, is cut into slots whose length is a power of two of the time unit. Time-sensitive packets always go in, stamped with the start time of the slot their flow is assigned to. Best-effort packets may use only the part of a slot that time-sensitive traffic leaves free, and they are turned away if their transmission would run past the start of the next slot.

The block keeps two pieces of timing state. The first is the time at which the last queued packet will have finished (the queue-end time). The second is the start of the next slot, which steps forward whenever the upper bits of the synchronized time change. At each slot crossing the queue-end time is raised to the start of the new slot if it lies earlier. The flow-to-slot table lives outside the block: the block presents the flow number on an address port and reads the slot start back in the same cycle. Every decision shows up one clock after the descriptor, either as an enqueue request carrying eligible time, traffic class and a rank of zero, or as a one-cycle drop pulse. Best-effort drops are also tallied in a counter.

Top module: `slot_admit`

## Requirements
- R1: During and after reset, until a descriptor is taken, enqValid and dropValid are 0 and beDropCount is 0. Reset places the block in slot 0, with a queue-end time of 0 and a next-slot start of 2^SLOT_LOG2.
- R2: A time-sensitive descriptor (descValid=1, descIsTs=1) is always admitted. One cycle later enqValid=1, enqIsTs=1 and enqEligTime equals the tblData returned for tblAddr, which is the descriptor's descFlowId.
- R3: An admitted time-sensitive descriptor adds its descDelay to the queue-end time.
- R4: An admitted best-effort descriptor (descIsTs=0) has enqEligTime equal to the queue-end time, and the queue-end time then grows by its descDelay.
- R5: A best-effort descriptor is admitted when queue-end time plus descDelay is less than or equal to the next-slot start, so exact equality admits. Otherwise it is dropped and the queue-end time does not change.
- R6: On any clock where syncTime[TIME_W-1:SLOT_LOG2] differs from its value at the previous clock, the next-slot start becomes (that field + 1) * 2^SLOT_LOG2. A descriptor in that same cycle is judged against the new value.
- R7: On such a slot crossing, a queue-end time below the new slot start (field * 2^SLOT_LOG2) is raised to that start before any descriptor in that cycle is judged.
- R8: enqRank is 0 on every enqueue request.
- R9: Each descriptor gives exactly one outcome one cycle later: either enqValid or dropValid, each a single-cycle pulse. Each drop adds 1 to beDropCount, and beDropCount changes at no other time.
- R10: A cycle with descValid=0 produces neither enqValid nor dropValid on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncTime | input | TIME_W | Synchronized time in time units |
| descValid | input | 1 | Descriptor present this cycle |
| descIsTs | input | 1 | 1 = time-sensitive, 0 = best-effort |
| descFlowId | input | FLOW_W | Flow number of the descriptor |
| descDelay | input | DELAY_W | Transmission delay in time units |
| tblAddr | output | FLOW_W | Flow-to-slot table read address |
| tblData | input | TIME_W | Slot start time read from the table |
| enqValid | output | 1 | Enqueue request pulse |
| enqIsTs | output | 1 | Class of the enqueued packet |
| enqEligTime | output | TIME_W | Eligible time of the enqueued packet |
| enqRank | output | RANK_W | Rank of the enqueued packet, always 0 |
| dropValid | output | 1 | Drop pulse for a best-effort descriptor |
| beDropCount | output | CNT_W | Running count of best-effort drops |

## Verification
The bench goes after the exact-fit boundary, where a best-effort packet ends precisely on the next slot start. A design that used a strict comparison would drop that packet, and one that let the sum wrap would admit oversized packets. It also jumps the time input across several slots at once while a descriptor is present. A design that advanced the next-slot start by a single slot, or raised the queue-end time one cycle late, would then give a stale eligible time or a wrong admit decision. Time-sensitive packets issued after a best-effort packet check that their delay is added to the queue-end time and that their eligible time comes from the table and not from that register. Drop pulses are compared cycle by cycle against the counter.

// File: rtl/slot_admit_pkg.sv
package slot_admit_pkg;
  typedef struct packed {
    logic admitTs;
    logic admitBe;
    logic dropBe;
  } admitStrobe_t;
endpackage

// File: rtl/slot_admit_ctrl.sv
module slot_admit_ctrl
  import slot_admit_pkg::*;
(
  input  logic         descValid,
  input  logic         descIsTs,
  input  logic         beFits,
  output admitStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    if (descValid) begin
      if (descIsTs)    strobe.admitTs = 1'b1;
      else if (beFits) strobe.admitBe = 1'b1;
      else             strobe.dropBe  = 1'b1;
    end
  end
endmodule

// File: rtl/slot_admit_dp.sv
module slot_admit_dp
  import slot_admit_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int SLOT_LOG2 = 17,
  parameter int DELAY_W   = 20,
  parameter int CNT_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIME_W-1:0]  syncTime,
  input  logic [DELAY_W-1:0] descDelay,
  input  logic [TIME_W-1:0]  tblData,
  input  admitStrobe_t       strobe,
  output logic               beFits,
  output logic               enqValid,
  output logic               enqIsTs,
  output logic [TIME_W-1:0]  enqEligTime,
  output logic               dropValid,
  output logic [CNT_W-1:0]   beDropCount
);
  localparam int IDX_W = TIME_W - SLOT_LOG2;
  localparam logic [TIME_W-1:0] SLOT_LEN = TIME_W'(1) << SLOT_LOG2;

  logic [IDX_W-1:0]  slotIdxQ, nowIdx, nextIdx;
  logic [TIME_W-1:0] nextSlotQ, lastPktQ;
  logic [TIME_W-1:0] curStart, nextStartNow, lpBase, nextEff;
  logic [TIME_W:0]   lpPlus;
  logic              crossing;

  assign nowIdx       = syncTime[TIME_W-1:SLOT_LOG2];
  assign nextIdx      = nowIdx + IDX_W'(1);
  assign crossing     = (nowIdx != slotIdxQ);
  assign curStart     = {nowIdx, {SLOT_LOG2{1'b0}}};
  assign nextStartNow = {nextIdx, {SLOT_LOG2{1'b0}}};
  assign lpBase       = (crossing && (lastPktQ < curStart)) ? curStart : lastPktQ;
  assign nextEff      = crossing ? nextStartNow : nextSlotQ;
  assign lpPlus       = {1'b0, lpBase} + {{(TIME_W + 1 - DELAY_W){1'b0}}, descDelay};
  assign beFits       = (lpPlus <= {1'b0, nextEff});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdxQ    <= '0;
      nextSlotQ   <= SLOT_LEN;
      lastPktQ    <= '0;
      enqValid    <= 1'b0;
      enqIsTs     <= 1'b0;
      enqEligTime <= '0;
      dropValid   <= 1'b0;
      beDropCount <= '0;
    end else begin
      slotIdxQ    <= nowIdx;
      nextSlotQ   <= nextEff;
      lastPktQ    <= (strobe.admitTs || strobe.admitBe) ? lpPlus[TIME_W-1:0] : lpBase;
      enqValid    <= strobe.admitTs || strobe.admitBe;
      enqIsTs     <= strobe.admitTs;
      enqEligTime <= strobe.admitTs ? tblData : lpBase;
      dropValid   <= strobe.dropBe;
      beDropCount <= beDropCount + CNT_W'(strobe.dropBe);
    end
  end
endmodule

// File: rtl/slot_admit.sv
module slot_admit
  import slot_admit_pkg::*;
#(
  parameter int TIME_W    = 32,
  parameter int SLOT_LOG2 = 17,
  parameter int FLOW_W    = 4,
  parameter int DELAY_W   = 20,
  parameter int RANK_W    = 8,
  parameter int CNT_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIME_W-1:0]  syncTime,
  input  logic               descValid,
  input  logic               descIsTs,
  input  logic [FLOW_W-1:0]  descFlowId,
  input  logic [DELAY_W-1:0] descDelay,
  output logic [FLOW_W-1:0]  tblAddr,
  input  logic [TIME_W-1:0]  tblData,
  output logic               enqValid,
  output logic               enqIsTs,
  output logic [TIME_W-1:0]  enqEligTime,
  output logic [RANK_W-1:0]  enqRank,
  output logic               dropValid,
  output logic [CNT_W-1:0]   beDropCount
);
  admitStrobe_t strobe;
  logic         beFits;

  assign tblAddr = descFlowId;
  assign enqRank = '0;

  slot_admit_ctrl i_ctrl (
    .descValid (descValid),
    .descIsTs  (descIsTs),
    .beFits    (beFits),
    .strobe    (strobe)
  );

  slot_admit_dp #(
    .TIME_W    (TIME_W),
    .SLOT_LOG2 (SLOT_LOG2),
    .DELAY_W   (DELAY_W),
    .CNT_W     (CNT_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .syncTime    (syncTime),
    .descDelay   (descDelay),
    .tblData     (tblData),
    .strobe      (strobe),
    .beFits      (beFits),
    .enqValid    (enqValid),
    .enqIsTs     (enqIsTs),
    .enqEligTime (enqEligTime),
    .dropValid   (dropValid),
    .beDropCount (beDropCount)
  );
endmodule

// File: rtl/slot_admit_checker.sv
module slot_admit_checker #(
  parameter int TIME_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              descValid,
  input logic              descIsTs,
  input logic [TIME_W-1:0] tblData,
  input logic              enqValid,
  input logic              enqIsTs,
  input logic [TIME_W-1:0] enqEligTime,
  input logic              dropValid,
  input logic [CNT_W-1:0]  beDropCount
);
  assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rstN)
    descValid |=> (enqValid ^ dropValid));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !descValid |=> (!enqValid && !dropValid));

  assert_ts_admit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descIsTs) |=> (enqValid && enqIsTs && enqEligTime == $past(tblData)));

  assert_drop_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    dropValid |-> (beDropCount == $past(beDropCount) + CNT_W'(1)));

  assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !dropValid |-> $stable(beDropCount));
endmodule

bind slot_admit slot_admit_checker #(.TIME_W(TIME_W), .CNT_W(CNT_W)) i_checker (
  .clk         (clk),
  .rstN        (rstN),
  .descValid   (descValid),
  .descIsTs    (descIsTs),
  .tblData     (tblData),
  .enqValid    (enqValid),
  .enqIsTs     (enqIsTs),
  .enqEligTime (enqEligTime),
  .dropValid   (dropValid),
  .beDropCount (beDropCount)
);

// File: tb/test_slot_admit.sv
`timescale 1ns/1ps
module test_slot_admit;
  localparam int TIME_W = 32, SLOT_LOG2 = 17, FLOW_W = 4, DELAY_W = 20, RANK_W = 8, CNT_W = 16;
  localparam longint SLOT = longint'(1) << SLOT_LOG2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [TIME_W-1:0]  syncTime = '0;
  logic               descValid = 1'b0, descIsTs = 1'b0;
  logic [FLOW_W-1:0]  descFlowId = '0;
  logic [DELAY_W-1:0] descDelay = '0;
  logic [FLOW_W-1:0]  tblAddr;
  logic [TIME_W-1:0]  tblData;
  logic               enqValid, enqIsTs, dropValid;
  logic [TIME_W-1:0]  enqEligTime;
  logic [RANK_W-1:0]  enqRank;
  logic [CNT_W-1:0]   beDropCount;
  logic [TIME_W-1:0]  flowTable [0:(1<<FLOW_W)-1];

  int checks = 0, failures = 0;

  always #2 clk = ~clk;
  assign tblData = flowTable[tblAddr];

  slot_admit #(.TIME_W(TIME_W), .SLOT_LOG2(SLOT_LOG2), .FLOW_W(FLOW_W),
               .DELAY_W(DELAY_W), .RANK_W(RANK_W), .CNT_W(CNT_W)) i_slot_admit (
    .clk(clk), .rstN(rstN), .syncTime(syncTime), .descValid(descValid),
    .descIsTs(descIsTs), .descFlowId(descFlowId), .descDelay(descDelay),
    .tblAddr(tblAddr), .tblData(tblData), .enqValid(enqValid), .enqIsTs(enqIsTs),
    .enqEligTime(enqEligTime), .enqRank(enqRank), .dropValid(dropValid),
    .beDropCount(beDropCount));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  longint mLast, mNext, mIdx, mElig, mCnt;
  bit     mEnq, mTs, mDrop;
  always @(posedge clk) begin
    if (!rstN) begin
      mLast = 0; mNext = SLOT; mIdx = 0; mCnt = 0; mEnq = 0; mTs = 0; mDrop = 0; mElig = 0;
    end else begin
      longint idx, lb, ne, d;
      idx = longint'(syncTime) >> SLOT_LOG2;
      lb = mLast; ne = mNext; d = longint'(descDelay);
      if (idx != mIdx) begin
        if (lb < idx * SLOT) lb = idx * SLOT;
        ne = (idx + 1) * SLOT;
      end
      mIdx = idx; mNext = ne; mEnq = 0; mDrop = 0;
      if (descValid) begin
        if (descIsTs) begin
          mEnq = 1; mTs = 1; mElig = longint'(tblData); lb = lb + d;
        end else if (lb + d <= ne) begin
          mEnq = 1; mTs = 0; mElig = lb; lb = lb + d;
        end else begin
          mDrop = 1; mCnt = mCnt + 1;
        end
      end
      mLast = lb;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(enqValid == mEnq, "R9/R10 enqValid", enqValid, mEnq);
      check(dropValid == mDrop, "R5/R9 dropValid", dropValid, mDrop);
      check(longint'(beDropCount) == mCnt, "R9 beDropCount", beDropCount, mCnt);
      if (mEnq) begin
        check(enqIsTs == mTs, "R2 enqIsTs", enqIsTs, mTs);
        check(longint'(enqEligTime) == mElig, mTs ? "R2 TS eligible time" : "R4 BE eligible time",
              enqEligTime, mElig);
        check(enqRank == '0, "R8 rank", enqRank, 0);
      end
    end
  end

  task automatic issue(input bit ts, input int flow, input longint dly);
    descValid = 1'b1; descIsTs = ts; descFlowId = FLOW_W'(flow); descDelay = DELAY_W'(dly);
    @(negedge clk);
    descValid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << FLOW_W); i++) flowTable[i] = TIME_W'(longint'(i) * SLOT);
    flowTable[3] = 32'd500000;
    repeat (3) @(negedge clk);
    check(!enqValid && !dropValid, "R1 reset outputs", {enqValid, dropValid}, 0);
    check(beDropCount == '0, "R1 reset count", beDropCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!enqValid && !dropValid, "R1 idle after reset", {enqValid, dropValid}, 0);

    // exact fit against first boundary
    issue(1'b0, 0, SLOT);
    check(enqValid && !enqIsTs && enqEligTime == 0, "R5 exact fit admitted", enqEligTime, 0);
    issue(1'b0, 0, 1);
    check(dropValid && !enqValid, "R5 overrun dropped", dropValid, 1);
    check(beDropCount == 1, "R9 count after drop", beDropCount, 1);
    @(negedge clk);
    check(!dropValid && !enqValid, "R10 single pulse", dropValid, 0);

    // slot crossing in the same cycle as a descriptor
    syncTime = TIME_W'(SLOT);
    issue(1'b0, 0, 100);
    check(enqValid && enqEligTime == TIME_W'(SLOT), "R4 elig after drop unchanged", enqEligTime, SLOT);
    issue(1'b0, 0, SLOT - 100);
    check(enqValid && enqEligTime == TIME_W'(SLOT + 100), "R6 next boundary advanced", enqEligTime, SLOT + 100);

    // jump two slots: queue-end raised, then TS adds its delay
    syncTime = TIME_W'(3 * SLOT + 5);
    issue(1'b1, 3, 1000);
    check(enqValid && enqIsTs && enqEligTime == 500000, "R2 table eligible", enqEligTime, 500000);
    issue(1'b0, 0, 10);
    check(enqValid && enqEligTime == TIME_W'(3 * SLOT + 1000), "R3/R7 raised and advanced",
          enqEligTime, 3 * SLOT + 1000);
    check(enqRank == '0, "R8 rank zero", enqRank, 0);
    @(negedge clk);
    check(!enqValid && !dropValid, "R10 idle cycle", {enqValid, dropValid}, 0);

    // random traffic with running time
    for (int c = 0; c < 4000; c++) begin
      syncTime = syncTime + 32'd4096;
      descValid = ($urandom_range(1, 0) == 1);
      descIsTs = ($urandom_range(9, 0) < 3);
      descFlowId = FLOW_W'($urandom_range((1 << FLOW_W) - 1, 0));
      descDelay = DELAY_W'($urandom_range(40000, 1));
      if (c % 500 == 0) flowTable[c % 16] = syncTime + TIME_W'(SLOT);
      @(negedge clk);
    end
    descValid = 1'b0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end
endmodule